// File: doc/BRIEF.md
# 64-bit Target Burst Read Sequencer

This block is the target side of a parallel shared bus that answers 64-bit memory read bursts. It watches for the address phase, holds the address, command and width request, and compares the upper address bits with a programmed window base. When a matching 64-bit memory read is seen, the block runs a fixed schedule. It pulses a start strobe toward a simple synchronous backend memory, claims the transaction, agrees to the wide transfer, and then presents one 64-bit word per data phase with no target wait states until the initiator ends the burst.

The backend port is a read strobe with a word address counted in 32-bit units. It has no back-pressure: a word must come back on `mem_rdata` one clock after each strobe. The read strobes are issued ahead of the bus into a small prefetch buffer, and the buffer never holds more than `DEPTH` words in flight plus stored. On the bus side, `trdy_n` low acts as the valid signal for `ad_out`, and the initiator's `irdy_n` acts as ready. A data phase completes only on a clock edge where both are low. While `irdy_n` is high, the word is held. At the end of a burst the unread prefetched words are dropped.

Top module: `pcit_burst_read`

## Requirements
- R1: A transaction is accepted only when, at the clock edge where `frame_n` first goes low, `req64_n` is low, `cbe` equals 4'b0110, `ad_lo_in[1:0]` equals 2'b00, and `ad_lo_in[31:WIN_LOG2]` equals `mem_base`. Clock 1 is the clock that ends at that edge.
- R2: For an accepted transaction, `bk_start` is high for exactly one clock, and that clock is clock 3.
- R3: From clock 4 until the last data phase, `ctl_oe` is high, `devsel_n` and `ack64_n` are low, and `stop_n` is high. Before clock 4, `ctl_oe` is low.
- R4: The first data phase is clock 7: `trdy_n` is low, `ad_oe` is high, and `ad_out` carries the backend word at the start offset `ad_lo_in[WIN_LOG2-1:2]`. Before clock 7, `trdy_n` is high and `ad_oe` is low.
- R5: Each data phase that completes (`trdy_n` and `irdy_n` both low at the edge) moves `ad_out` to the next backend word. While `irdy_n` is high, `ad_out` holds its value.
- R6: The first backend read strobe (`mem_rd`) is in clock 4 at the start offset. Each following strobe of the same burst addresses the previous address plus 2, wrapping modulo 2^(WIN_LOG2-2). No strobe occurs before clock 4.
- R7: The number of backend reads issued minus the number of completed data phases never exceeds `DEPTH`.
- R8: The last data phase completes at an edge where `frame_n` is high. In the next clock, `trdy_n`, `devsel_n` and `ack64_n` are high with `ctl_oe` high and `ad_oe` low. In the clock after that, `ctl_oe` is low.
- R9: `bk_done` is high for exactly that one clock after the last data phase, and `mem_rd` is low in it.
- R10: A window miss, any other command, or `req64_n` high leaves `ctl_oe`, `ad_oe`, `bk_start`, `mem_rd` and `bk_done` low. A later matching transaction is still served.
- R11: While `rst_n` is low, `ctl_oe`, `ad_oe`, `bk_start`, `mem_rd` and `bk_done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mem_base | input | 32-WIN_LOG2 | Programmed base of the memory window, upper address bits |
| frame_n | input | 1 | Initiator frame, active low |
| req64_n | input | 1 | Initiator 64-bit transfer request, active low |
| irdy_n | input | 1 | Initiator ready, active low |
| cbe | input | 4 | Command lane during the address phase |
| ad_lo_in | input | 32 | Lower address/data lanes as seen in the address phase |
| ad_out | output | 64 | Read data driven during data phases |
| ad_oe | output | 1 | Enable for driving `ad_out` onto the bus |
| trdy_n | output | 1 | Target ready, active low |
| devsel_n | output | 1 | Device select (claim), active low |
| ack64_n | output | 1 | 64-bit acknowledge, active low |
| stop_n | output | 1 | Target stop, always inactive when driven |
| ctl_oe | output | 1 | Enable for the target control outputs |
| bk_start | output | 1 | One-clock strobe that starts the backend transfer |
| mem_rd | output | 1 | Backend read strobe |
| mem_addr | output | WIN_LOG2-2 | Backend word address in 32-bit units |
| mem_rdata | input | 64 | Backend read data, valid one clock after `mem_rd` |
| bk_done | output | 1 | One-clock strobe at the end of the burst |

## Verification
The bench builds the block with WIN_LOG2 = 12 and DEPTH = 4. With these values the offset is 10 bits wide, so a burst that starts just below 4 KiB crosses the address wrap within a few phases. The four-entry buffer also fills after only two initiator wait clocks, which makes the throttle of the read strobe visible. Bursts of 1, 4, 6 and 2 phases are checked against a backend model whose words encode their own address, and misses by window, low address bits, command and width are mixed in between.

// File: rtl/pcit_pkg.sv
package pcit_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DECODE,
    ST_START,
    ST_CLAIM,
    ST_TURN1,
    ST_TURN2,
    ST_DATA,
    ST_TAIL
  } pcit_state_e;

  localparam logic [3:0] CMD_MEM_READ = 4'b0110;

endpackage

// File: rtl/pcit_addr_decode.sv
module pcit_addr_decode
  import pcit_pkg::*;
#(
  parameter int WIN_LOG2 = 12,
  localparam int OFS_W = WIN_LOG2 - 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 capture,
  input  logic [31:0]          ad_lo_in,
  input  logic [3:0]           cbe,
  input  logic                 req64_n,
  input  logic [31:WIN_LOG2]   mem_base,
  output logic                 hit,
  output logic [OFS_W-1:0]     start_ofs
);

  logic [31:0] cap_ad_q;
  logic [3:0]  cap_cmd_q;
  logic        cap_r64n_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_ad_q   <= '0;
      cap_cmd_q  <= '0;
      cap_r64n_q <= 1'b1;
    end else if (capture) begin
      cap_ad_q   <= ad_lo_in;
      cap_cmd_q  <= cbe;
      cap_r64n_q <= req64_n;
    end
  end

  logic cmd_ok, win_ok, order_ok;
  assign cmd_ok    = (cap_cmd_q == CMD_MEM_READ) && !cap_r64n_q;
  assign win_ok    = (cap_ad_q[31:WIN_LOG2] == mem_base);
  assign order_ok  = (cap_ad_q[1:0] == 2'b00);
  assign hit       = cmd_ok && win_ok && order_ok;
  assign start_ofs = cap_ad_q[WIN_LOG2-1:2];

endmodule

// File: rtl/pcit_prefetch_fifo.sv
module pcit_prefetch_fifo #(
  parameter int DW    = 64,
  parameter int DEPTH = 4,
  localparam int PW = $clog2(DEPTH),
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push_valid,
  input  logic [DW-1:0] push_data,
  input  logic          pop_ready,
  output logic          pop_valid,
  output logic [DW-1:0] pop_data,
  output logic [LW-1:0] level
);

  logic [DW-1:0] store_q [DEPTH];
  logic [PW-1:0] wr_ptr_q, rd_ptr_q;
  logic          do_push, do_pop;

  assign pop_valid = (level != '0);
  assign pop_data  = store_q[rd_ptr_q];
  assign do_push   = push_valid && !flush;
  assign do_pop    = pop_ready && pop_valid && !flush;

  always_ff @(posedge clk) begin
    if (do_push) store_q[wr_ptr_q] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      level    <= '0;
    end else if (flush) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      level    <= '0;
    end else begin
      if (do_push)
        wr_ptr_q <= (wr_ptr_q == PW'(DEPTH - 1)) ? '0 : wr_ptr_q + 1'b1;
      if (do_pop)
        rd_ptr_q <= (rd_ptr_q == PW'(DEPTH - 1)) ? '0 : rd_ptr_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

  // R7: a word arriving from the backend always finds a free slot
  a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    do_push |-> (level < LW'(DEPTH)));

endmodule

// File: rtl/pcit_fetch_ctrl.sv
module pcit_fetch_ctrl #(
  parameter int OFS_W = 10,
  parameter int DEPTH = 4,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [OFS_W-1:0] load_ofs,
  input  logic             enable,
  input  logic             flush,
  input  logic [LW-1:0]    level,
  output logic             mem_rd,
  output logic [OFS_W-1:0] mem_addr,
  output logic             push_valid
);

  logic             rd_q;
  logic [OFS_W-1:0] addr_q;
  logic [LW:0]      pending;

  assign pending    = {1'b0, level} + {{LW{1'b0}}, rd_q};
  assign mem_rd     = enable && (pending < (LW + 1)'(DEPTH));
  assign mem_addr   = addr_q;
  assign push_valid = rd_q && !flush;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q   <= 1'b0;
      addr_q <= '0;
    end else begin
      rd_q <= mem_rd;
      if (load)        addr_q <= load_ofs;
      else if (mem_rd) addr_q <= addr_q + OFS_W'(2);
    end
  end

  // R6: back-to-back strobes step the word address by two
  a_r6_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && $past(mem_rd)) |-> (mem_addr == $past(mem_addr) + OFS_W'(2)));

  // R7: stored plus in-flight words stay within the buffer
  a_r7_credit_bound: assert property (@(posedge clk) disable iff (!rst_n)
    pending <= (LW + 1)'(DEPTH));

endmodule

// File: rtl/pcit_burst_read.sv
module pcit_burst_read
  import pcit_pkg::*;
#(
  parameter int WIN_LOG2 = 12,
  parameter int DEPTH    = 4,
  localparam int OFS_W = WIN_LOG2 - 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [31:WIN_LOG2] mem_base,
  input  logic               frame_n,
  input  logic               req64_n,
  input  logic               irdy_n,
  input  logic [3:0]         cbe,
  input  logic [31:0]        ad_lo_in,
  output logic [63:0]        ad_out,
  output logic               ad_oe,
  output logic               trdy_n,
  output logic               devsel_n,
  output logic               ack64_n,
  output logic               stop_n,
  output logic               ctl_oe,
  output logic               bk_start,
  output logic               mem_rd,
  output logic [OFS_W-1:0]   mem_addr,
  input  logic [63:0]        mem_rdata,
  output logic               bk_done
);

  localparam int LW = $clog2(DEPTH + 1);

  pcit_state_e state_q, state_d;
  logic        frame_q;
  logic        capture, hit;
  logic [OFS_W-1:0] start_ofs;
  logic        in_claim, in_data, in_tail;
  logic        push_valid, pop_ready, head_valid;
  logic [LW-1:0] level;

  // sequencer
  assign capture = (state_q == ST_IDLE) && !frame_n && frame_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (capture) state_d = ST_DECODE;
      ST_DECODE: state_d = hit ? ST_START : ST_IDLE;
      ST_START:  state_d = ST_CLAIM;
      ST_CLAIM:  state_d = ST_TURN1;
      ST_TURN1:  state_d = ST_TURN2;
      ST_TURN2:  state_d = ST_DATA;
      ST_DATA:   if (!irdy_n && frame_n) state_d = ST_TAIL;
      ST_TAIL:   state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      frame_q <= 1'b1;
    end else begin
      state_q <= state_d;
      frame_q <= frame_n;
    end
  end

  // address phase decode
  pcit_addr_decode #(.WIN_LOG2(WIN_LOG2)) u_decode (
    .clk       (clk),
    .rst_n     (rst_n),
    .capture   (capture),
    .ad_lo_in  (ad_lo_in),
    .cbe       (cbe),
    .req64_n   (req64_n),
    .mem_base  (mem_base),
    .hit       (hit),
    .start_ofs (start_ofs)
  );

  // bus-facing decodes of the sequencer state
  assign in_claim = (state_q == ST_CLAIM) || (state_q == ST_TURN1) ||
                    (state_q == ST_TURN2) || (state_q == ST_DATA);
  assign in_data  = (state_q == ST_DATA);
  assign in_tail  = (state_q == ST_TAIL);

  assign ctl_oe   = in_claim || in_tail;
  assign devsel_n = !in_claim;
  assign ack64_n  = !in_claim;
  assign trdy_n   = !in_data;
  assign stop_n   = 1'b1;
  assign ad_oe    = in_data;
  assign bk_start = (state_q == ST_START);
  assign bk_done  = in_tail;

  // backend read issue, running ahead of the bus
  pcit_fetch_ctrl #(.OFS_W(OFS_W), .DEPTH(DEPTH)) u_fetch (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       ((state_q == ST_DECODE) && hit),
    .load_ofs   (start_ofs),
    .enable     (in_claim),
    .flush      (in_tail),
    .level      (level),
    .mem_rd     (mem_rd),
    .mem_addr   (mem_addr),
    .push_valid (push_valid)
  );

  // prefetch buffer; a data phase is the pop handshake
  assign pop_ready = in_data && !irdy_n;

  pcit_prefetch_fifo #(.DW(64), .DEPTH(DEPTH)) u_fifo (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush      (in_tail),
    .push_valid (push_valid),
    .push_data  (mem_rdata),
    .pop_ready  (pop_ready),
    .pop_valid  (head_valid),
    .pop_data   (ad_out),
    .level      (level)
  );

  // R2: the start strobe lasts one clock and is followed by the claim
  a_r2_start_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    bk_start |=> (!bk_start && !devsel_n));

  // R3: claim signals are only low while the control outputs are enabled
  a_r3_claim_driven: assert property (@(posedge clk) disable iff (!rst_n)
    (!devsel_n || !ack64_n) |-> ctl_oe);

  // R4: the buffer already holds a word whenever a data phase is offered
  a_r4_head_ready: assert property (@(posedge clk) disable iff (!rst_n)
    ad_oe |-> head_valid);

  // R5: an initiator wait clock keeps the word on the bus
  a_r5_hold_on_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (ad_oe && irdy_n) |=> (ad_oe && $stable(ad_out)));

  // R8: control release happens only right after the done clock
  a_r8_release: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ctl_oe) |-> $past(bk_done));

  // R9: the done strobe lasts one clock and no read is issued with it
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    bk_done |-> (!mem_rd ##1 !bk_done));

endmodule

// File: tb/test_pcit_burst_read.sv
module test_pcit_burst_read;

  localparam int CLK_PERIOD = 10;
  localparam int WIN_LOG2   = 12;
  localparam int DEPTH      = 4;
  localparam int OFS_W      = WIN_LOG2 - 2;

  logic               clk = 1'b0;
  logic               rst_n;
  logic [31:WIN_LOG2] mem_base;
  logic               frame_n, req64_n, irdy_n;
  logic [3:0]         cbe;
  logic [31:0]        ad_lo_in;
  logic [63:0]        ad_out;
  logic               ad_oe, trdy_n, devsel_n, ack64_n, stop_n, ctl_oe;
  logic               bk_start, mem_rd, bk_done;
  logic [OFS_W-1:0]   mem_addr;
  logic [63:0]        mem_rdata = '0;

  int n_tests = 0;
  int n_fail  = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  pcit_burst_read #(.WIN_LOG2(WIN_LOG2), .DEPTH(DEPTH)) i_pcit_burst_read (
    .clk(clk), .rst_n(rst_n), .mem_base(mem_base), .frame_n(frame_n),
    .req64_n(req64_n), .irdy_n(irdy_n), .cbe(cbe), .ad_lo_in(ad_lo_in),
    .ad_out(ad_out), .ad_oe(ad_oe), .trdy_n(trdy_n), .devsel_n(devsel_n),
    .ack64_n(ack64_n), .stop_n(stop_n), .ctl_oe(ctl_oe), .bk_start(bk_start),
    .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rdata(mem_rdata), .bk_done(bk_done)
  );

  function automatic logic [63:0] word_at(logic [OFS_W-1:0] a);
    return {16'hD00D, 6'd0, a, 16'h7E57, 6'd0, ~a};
  endfunction

  // backend model: one clock of read latency
  always @(posedge clk) mem_rdata <= word_at(mem_addr);

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 20000, 0);
    summary();
    $finish;
  end

  task automatic bus_idle(input int n);
    frame_n = 1'b1; req64_n = 1'b1; irdy_n = 1'b1; cbe = '0; ad_lo_in = '0;
    repeat (n) @(negedge clk);
  endtask

  // matching burst of nph data phases; stall[c] makes clock c an initiator wait
  task automatic run_hit(input logic [31:0] addr, input int nph,
                         input logic [63:0] stall);
    logic [OFS_W-1:0] start;
    int  done  = 0;
    int  reads = 0;
    bit  tail  = 1'b0;
    start = addr[WIN_LOG2-1:2];
    @(negedge clk);
    frame_n = 1'b0; req64_n = 1'b0; cbe = 4'b0110; ad_lo_in = addr; irdy_n = 1'b1;
    for (int c = 2; c < 60; c++) begin
      @(negedge clk);
      if (tail) begin
        chk({trdy_n, devsel_n, ack64_n, ctl_oe, ad_oe} == 5'b11110, "R8 tail drive",
            {trdy_n, devsel_n, ack64_n, ctl_oe, ad_oe}, 5'b11110);
        chk(bk_done && !mem_rd, "R9 done strobe", {bk_done, mem_rd}, 2'b10);
        irdy_n = 1'b1;
        @(negedge clk);
        chk(!ctl_oe && !bk_done, "R8 release", {ctl_oe, bk_done}, 2'b00);
        break;
      end
      chk(bk_start == (c == 3), "R1/R2 start strobe clock", bk_start, (c == 3));
      if (c <= 3)
        chk(!ctl_oe && devsel_n, "R3 unclaimed before clock 4", {ctl_oe, devsel_n}, 2'b01);
      else
        chk(ctl_oe && !devsel_n && !ack64_n && stop_n, "R3 claim",
            {ctl_oe, devsel_n, ack64_n, stop_n}, 4'b1001);
      if (c >= 7)
        chk(!trdy_n && ad_oe && ad_out == word_at(start + OFS_W'(2 * done)),
            (done == 0) ? "R4 first data" : "R5 data sequence",
            ad_out, word_at(start + OFS_W'(2 * done)));
      else
        chk(trdy_n && !ad_oe, "R4 no data before clock 7", {trdy_n, ad_oe}, 2'b10);
      if (c < 4) chk(!mem_rd, "R6 no read before clock 4", mem_rd, 1'b0);
      if (c == 4) chk(mem_rd, "R6 first read in clock 4", mem_rd, 1'b1);
      if (mem_rd) begin
        chk(mem_addr == start + OFS_W'(2 * reads), "R6 address step",
            mem_addr, start + OFS_W'(2 * reads));
        reads++;
      end
      chk(reads - done <= DEPTH, "R7 prefetch bound", reads - done, DEPTH);
      cbe = '0; ad_lo_in = '0;
      irdy_n  = stall[c];
      frame_n = (done == nph - 1) && !stall[c];
      req64_n = frame_n;
      if (c >= 7 && !irdy_n) begin
        done++;
        if (done == nph) tail = 1'b1;
      end
    end
    bus_idle(2);
  endtask

  // any transaction that must not be claimed
  task automatic run_miss(input logic [31:0] addr, input logic [3:0] cmd,
                          input logic r64, input string req);
    @(negedge clk);
    frame_n = 1'b0; req64_n = r64; cbe = cmd; ad_lo_in = addr; irdy_n = 1'b1;
    for (int c = 2; c <= 10; c++) begin
      @(negedge clk);
      chk({ctl_oe, ad_oe, bk_start, mem_rd, bk_done, devsel_n} == 6'b000001, req,
          {ctl_oe, ad_oe, bk_start, mem_rd, bk_done, devsel_n}, 6'b000001);
      cbe = '0; ad_lo_in = '0;
      if (c < 6) begin frame_n = 1'b0; irdy_n = 1'b0; end
      else       begin frame_n = 1'b1; irdy_n = 1'b1; req64_n = 1'b1; end
    end
    bus_idle(2);
  endtask

  initial begin
    rst_n = 1'b0;
    mem_base = 20'h80000;
    frame_n = 1'b1; req64_n = 1'b1; irdy_n = 1'b1; cbe = '0; ad_lo_in = '0;
    repeat (3) @(negedge clk);
    chk({ctl_oe, ad_oe, bk_start, mem_rd, bk_done} == 5'b0, "R11 reset outputs",
        {ctl_oe, ad_oe, bk_start, mem_rd, bk_done}, 5'b0);
    rst_n = 1'b1;
    bus_idle(2);

    run_hit(32'h8000_0100, 1, 64'h0);
    run_hit(32'h8000_0040, 4, 64'h0);
    run_hit(32'h8000_0FF0, 6, 64'h600);
    run_miss(32'h9000_0100, 4'b0110, 1'b0, "R1 R10 window miss");
    run_miss(32'h8000_0102, 4'b0110, 1'b0, "R1 R10 low address bits");
    run_miss(32'h8000_0100, 4'b0111, 1'b0, "R10 other command");
    run_miss(32'h8000_0100, 4'b0110, 1'b1, "R10 no 64-bit request");
    run_hit(32'h8000_0208, 2, 64'h0);

    summary();
    $finish;
  end

endmodule